// File: doc/BRIEF.md
# PWM Generator with Dead Band

This block is a 16-bit pulse-width timer with three compare channels and a clock prescaler. A shared period counter advances once per prescaler tick. Each channel compares the counter against its own duty value and produces a reference waveform. The block can present these waveforms in two ways. In the first, the three reference waveforms drive three output pins directly. In the second, the first two channels each drive a complementary high-side/low-side pin pair. After every transition of the reference, both pins of the pair are held low for a programmable dead time, so the two switches of a half-bridge never conduct together.

Period, duty and prescale values are held in shadow registers. New values reach the counter only at a period boundary, so software can change them at any time without producing a runt cycle. A decimating interrupt counter raises a one-clock interrupt after a programmed number of completed periods. This lets software service the timer less often than once per cycle. Output mode and dead time are static settings, changed only while the block is disabled.

Top module: `pwm_db_gen`

## Requirements
- R1: While en_i is low, and in the first clock after en_i falls, every bit of out_o and irq_o is low. The same holds during reset.
- R2: One PWM period lasts P*(psc_i+1) clocks. P is period_i, except that values 0 and 1 are treated as 2. psc_i is 8 bits, giving a divide ratio of 1 to 256.
- R3: With pair_mode_i = 0, out_o[c] for c = 0..2 is high for D_c*(psc_i+1) consecutive clocks per period. D_c is duty_i[16c+15:16c]. out_o[3] stays low.
- R4: A channel with duty 0 keeps its reference low. A duty greater than or equal to the effective period keeps it high for the whole period.
- R5: With pair_mode_i = 1, pair p (p = 0, 1) is driven by channel p and dead = db_i+1 clocks (1 to 4096). The high side out_o[2p] is high for D_p*(psc_i+1) - dead clocks. The low side out_o[2p+1] is high for (P-D_p)*(psc_i+1) - dead clocks. Channel 2 is unused in this mode.
- R6: In pair mode, out_o[2p] and out_o[2p+1] are never high in the same clock.
- R7: In pair mode, once one side of a pair falls, the other side rises exactly dead clocks later.
- R8: In pair mode, if the reference run for a side lasts dead clocks or fewer, that side stays low for the whole run.
- R9: Changes to period_i, duty_i and psc_i made during a period leave that period unchanged. They apply from the next period onward.
- R10: irq_o is a one-clock pulse at the end of every N-th period, where N is irq_n_i (values 0 and 1 both give an interrupt every period). The period count restarts after each interrupt and on enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears the counters and loads the shadow registers |
| pair_mode_i | input | 1 | 0: three independent outputs, 1: two complementary pairs |
| psc_i | input | 8 | Prescale value; divide ratio is psc_i+1 |
| period_i | input | 16 | Period in prescaled ticks |
| duty_i | input | 48 | Three 16-bit duty values, channel c at bits [16c+15:16c] |
| db_i | input | 12 | Dead time minus one, in clocks |
| irq_n_i | input | 8 | Periods per interrupt |
| out_o | output | 4 | PWM pins |
| irq_o | output | 1 | Decimated period interrupt |

## Verification
The bound checker watches four properties on every clock:
- the two sides of each pair are never high together;
- a pair side rises only after both sides have been low for at least the dead time;
- the interrupt is never longer than one clock;
- everything is quiet after a disable.

Exact pulse widths, period lengths, the exact dead gap, clamping of small periods and prescale limits, pulse suppression, interrupt decimation and the deferred effect of mid-period writes are shown only by the bench scenarios. The bench measures these as edge-to-edge intervals at the pins.

// File: rtl/pwm_db_pkg.sv
package pwm_db_pkg;
  typedef enum logic {
    MODE_INDEP = 1'b0,
    MODE_PAIR  = 1'b1
  } out_mode_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!en_i)        cnt_q <= '0;
    else if (cnt_q == div_i) cnt_q <= '0;
    else                   cnt_q <= cnt_q + PSC_W'(1);
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8,
  parameter int N_CH  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  tick_i,
  input  logic [PSC_W-1:0]      psc_i,
  input  logic [CNT_W-1:0]      period_i,
  input  logic [N_CH*CNT_W-1:0] duty_i,
  output logic [PSC_W-1:0]      psc_act_o,
  output logic [N_CH-1:0]       ref_o,
  output logic                  wrap_o
);
  logic [CNT_W-1:0] cnt_q, per_q, per_eff;
  logic [PSC_W-1:0] psc_q;
  logic             last_w, load_w;

  // periods below two ticks are clamped
  assign per_eff   = (period_i < CNT_W'(2)) ? CNT_W'(2) : period_i;
  assign last_w    = (cnt_q == per_q - CNT_W'(1));
  assign wrap_o    = en_i && tick_i && last_w;
  assign load_w    = !en_i || wrap_o;
  assign psc_act_o = psc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= CNT_W'(2);
      psc_q <= '0;
    end else begin
      if (load_w) begin
        per_q <= per_eff;
        psc_q <= psc_i;
      end
      if (!en_i || wrap_o) cnt_q <= '0;
      else if (tick_i)     cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [CNT_W-1:0] duty_q;
    logic             ref_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        duty_q <= '0;
        ref_q  <= 1'b0;
      end else begin
        if (load_w) duty_q <= duty_i[c*CNT_W +: CNT_W];
        ref_q <= en_i && (cnt_q < duty_q);
      end
    end
    assign ref_o[c] = ref_q;
  end
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DB_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            ref_i,
  input  logic [DB_W-1:0] db_i,
  output logic            hi_o,
  output logic            lo_o
);
  logic            ref_d_q, hi_q, lo_q;
  logic [DB_W-1:0] dcnt_q;
  logic            edge_w, settled_w;

  assign edge_w    = (ref_i != ref_d_q);
  assign settled_w = !edge_w && (dcnt_q == '0);
  assign hi_o      = hi_q;
  assign lo_o      = lo_q;

  // any reference edge restarts the dead window, both sides low meanwhile
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_d_q <= 1'b0;
      dcnt_q  <= '0;
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
    end else if (!en_i) begin
      ref_d_q <= 1'b0;
      dcnt_q  <= db_i;
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
    end else begin
      ref_d_q <= ref_i;
      if (edge_w)              dcnt_q <= db_i;
      else if (dcnt_q != '0)   dcnt_q <= dcnt_q - DB_W'(1);
      hi_q <= settled_w && ref_i;
      lo_q <= settled_w && !ref_i;
    end
  end
endmodule

// File: rtl/pwm_irq_div.sv
module pwm_irq_div #(
  parameter int IRQ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             evt_i,
  input  logic [IRQ_W-1:0] irq_n_i,
  output logic             irq_o
);
  logic [IRQ_W-1:0] rem_q, n_eff;
  logic             irq_q;

  assign n_eff = (irq_n_i == '0) ? IRQ_W'(1) : irq_n_i;
  assign irq_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= IRQ_W'(1);
      irq_q <= 1'b0;
    end else if (!en_i) begin
      rem_q <= n_eff;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (evt_i) begin
        if (rem_q <= IRQ_W'(1)) begin
          irq_q <= 1'b1;
          rem_q <= n_eff;
        end else begin
          rem_q <= rem_q - IRQ_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pwm_db_gen.sv
module pwm_db_gen
  import pwm_db_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 8,
  parameter int DB_W   = 12,
  parameter int IRQ_W  = 8,
  parameter int N_CH   = 3,
  parameter int N_PAIR = 2,
  localparam int OUT_W = (2*N_PAIR > N_CH) ? 2*N_PAIR : N_CH
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  pair_mode_i,
  input  logic [PSC_W-1:0]      psc_i,
  input  logic [CNT_W-1:0]      period_i,
  input  logic [N_CH*CNT_W-1:0] duty_i,
  input  logic [DB_W-1:0]       db_i,
  input  logic [IRQ_W-1:0]      irq_n_i,
  output logic [OUT_W-1:0]      out_o,
  output logic                  irq_o
);
  out_mode_e         mode;
  logic              tick_w, wrap_w;
  logic [PSC_W-1:0]  psc_act_w;
  logic [N_CH-1:0]   ref_w;
  logic [N_PAIR-1:0] hi_w, lo_w;

  assign mode = out_mode_e'(pair_mode_i);

  pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .div_i(psc_act_w), .tick_o(tick_w)
  );

  pwm_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W), .N_CH(N_CH)) u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tick_i(tick_w),
    .psc_i(psc_i), .period_i(period_i), .duty_i(duty_i),
    .psc_act_o(psc_act_w), .ref_o(ref_w), .wrap_o(wrap_w)
  );

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    pwm_deadband #(.DB_W(DB_W)) u_db (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .ref_i(ref_w[p]),
      .db_i(db_i), .hi_o(hi_w[p]), .lo_o(lo_w[p])
    );
  end

  pwm_irq_div #(.IRQ_W(IRQ_W)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .evt_i(wrap_w),
    .irq_n_i(irq_n_i), .irq_o(irq_o)
  );

  for (genvar k = 0; k < OUT_W; k++) begin : g_out
    logic indep_bit, pair_bit;
    if (k < N_CH) begin : g_i
      assign indep_bit = ref_w[k];
    end else begin : g_iz
      assign indep_bit = 1'b0;
    end
    if (k / 2 < N_PAIR) begin : g_p
      if (k % 2 == 0) begin : g_hi
        assign pair_bit = hi_w[k/2];
      end else begin : g_lo
        assign pair_bit = lo_w[k/2];
      end
    end else begin : g_pz
      assign pair_bit = 1'b0;
    end
    assign out_o[k] = (mode == MODE_PAIR) ? pair_bit : indep_bit;
  end
endmodule

// File: rtl/pwm_db_gen_chk.sv
module pwm_db_gen_chk #(
  parameter int N_PAIR = 2,
  parameter int OUT_W  = 4,
  parameter int DB_W   = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             pair_mode_i,
  input logic [DB_W-1:0]  db_i,
  input logic [OUT_W-1:0] out_o,
  input logic             irq_o
);
  // R1
  off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (out_o == '0 && !irq_o));

  // R10
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    logic [DB_W:0] quiet_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          quiet_q <= '0;
      else if (out_o[2*p] || out_o[2*p+1])  quiet_q <= '0;
      else if (quiet_q != '1)               quiet_q <= quiet_q + (DB_W+1)'(1);
    end

    // R6
    pair_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pair_mode_i |-> !(out_o[2*p] && out_o[2*p+1]));

    // R7
    dead_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pair_mode_i && $stable(pair_mode_i) &&
       ($rose(out_o[2*p]) || $rose(out_o[2*p+1])))
      |-> (quiet_q >= ((DB_W+1)'(db_i) + (DB_W+1)'(1))));
  end
endmodule

bind pwm_db_gen pwm_db_gen_chk #(.N_PAIR(N_PAIR), .OUT_W(OUT_W), .DB_W(DB_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .pair_mode_i(pair_mode_i),
  .db_i(db_i), .out_o(out_o), .irq_o(irq_o)
);

// File: tb/pwm_db_gen_tb.sv
module pwm_db_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en = 1'b0;
  logic        pair_mode = 1'b0;
  logic [7:0]  psc = '0;
  logic [15:0] period = 16'd10;
  logic [47:0] duty = '0;
  logic [11:0] db = '0;
  logic [7:0]  irq_n = '0;
  logic [3:0]  out;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_db_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .pair_mode_i(pair_mode),
    .psc_i(psc), .period_i(period), .duty_i(duty), .db_i(db),
    .irq_n_i(irq_n), .out_o(out), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard queues: expected widths per pin, out0 rise spacing, gap, irq spacing
  int wq [4][$];
  int pq [$];
  int gq [$];
  int iq [$];
  string wtag [4];
  string ptag, gtag, itag;

  logic [3:0] prev = '0;
  int  rise_t [4], fall_t [4], hcnt [4];
  bit  rise_v [4], fall_v [4];
  int  last_rise0 = 0, last_irq = 0;
  bit  lr_v = 0, li_v = 0;

  always @(negedge clk) begin
    if (!en) begin
      lr_v = 0; li_v = 0;
      for (int k = 0; k < 4; k++) begin rise_v[k] = 0; fall_v[k] = 0; end
    end
    for (int k = 0; k < 4; k++) begin
      if (out[k] && !prev[k]) begin
        if (k == 0) begin
          if (lr_v && pq.size() > 0) check(ptag, cyc - last_rise0, pq.pop_front());
          last_rise0 = cyc; lr_v = 1;
        end
        if (k == 1 && fall_v[0] && gq.size() > 0) check(gtag, cyc - fall_t[0], gq.pop_front());
        rise_t[k] = cyc; rise_v[k] = 1;
      end
      if (!out[k] && prev[k]) begin
        if (rise_v[k] && wq[k].size() > 0) check(wtag[k], cyc - rise_t[k], wq[k].pop_front());
        fall_t[k] = cyc; fall_v[k] = 1;
      end
      if (out[k]) hcnt[k]++;
    end
    if (irq) begin
      if (li_v && iq.size() > 0) check(itag, cyc - last_irq, iq.pop_front());
      last_irq = cyc; li_v = 1;
    end
    prev = out;
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setup(bit pm, int p_psc, int p_per, int d0, int d1, int d2, int p_db, int p_irq);
    en = 1'b0;
    step(3);
    pair_mode = pm; psc = 8'(p_psc); period = 16'(p_per);
    duty = {16'(d2), 16'(d1), 16'(d0)}; db = 12'(p_db); irq_n = 8'(p_irq);
    step(2);
    en = 1'b1;
  endtask

  task automatic push_w(int k, string tag, int w, int n);
    wtag[k] = tag;
    for (int i = 0; i < n; i++) wq[k].push_back(w);
  endtask

  task automatic drain(int max_cyc);
    int t0;
    t0 = cyc;
    while ((wq[0].size() + wq[1].size() + wq[2].size() + wq[3].size() +
            pq.size() + gq.size() + iq.size()) > 0 && (cyc - t0) < max_cyc) step(1);
    for (int k = 0; k < 4; k++)
      while (wq[k].size() > 0) begin
        n_chk++; n_fail++;
        $display("FAIL %s actual=none expected=%0d", wtag[k], wq[k].pop_front());
      end
    while (pq.size() > 0) begin n_chk++; n_fail++; $display("FAIL %s actual=none expected=%0d", ptag, pq.pop_front()); end
    while (gq.size() > 0) begin n_chk++; n_fail++; $display("FAIL %s actual=none expected=%0d", gtag, gq.pop_front()); end
    while (iq.size() > 0) begin n_chk++; n_fail++; $display("FAIL %s actual=none expected=%0d", itag, iq.pop_front()); end
  endtask

  task automatic high_count(int n, output int c [4]);
    for (int k = 0; k < 4; k++) hcnt[k] = 0;
    step(n);
    for (int k = 0; k < 4; k++) c[k] = hcnt[k];
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin : driver
    int hc [4];
    bit pv;
    step(3);
    // R1: reset state
    check("R1 reset out", int'(out), 0);
    check("R1 reset irq", int'(irq), 0);
    rst_ni = 1'b1;
    step(2);
    check("R1 idle out", int'(out), 0);

    // R3 R2: independent, divide 1, period 10
    setup(0, 0, 10, 3, 7, 0, 0, 1);
    step(30);
    push_w(0, "R3 out0 width", 3, 3);
    push_w(1, "R3 out1 width", 7, 3);
    ptag = "R2 period div1"; pq.push_back(10); pq.push_back(10);
    drain(200);
    high_count(50, hc);
    check("R4 duty 0 stays low", hc[2], 0);
    check("R3 out3 low in independent mode", hc[3], 0);

    // R2 R3 R4: prescale 4, duty >= period
    setup(0, 3, 6, 2, 6, 5, 0, 1);
    step(60);
    push_w(0, "R3 out0 width prescaled", 8, 2);
    push_w(2, "R3 out2 width prescaled", 20, 2);
    ptag = "R2 period div4"; pq.push_back(24); pq.push_back(24);
    drain(300);
    high_count(96, hc);
    check("R4 duty=period stays high", hc[1], 96);

    // R2: maximum prescale 256
    setup(0, 255, 2, 1, 0, 0, 0, 1);
    step(1100);
    push_w(0, "R2 width div256", 256, 2);
    ptag = "R2 period div256"; pq.push_back(512);
    drain(3000);

    // R2: period 1 clamps to 2
    setup(0, 0, 1, 1, 0, 0, 0, 1);
    step(10);
    push_w(0, "R2 width clamped period", 1, 3);
    ptag = "R2 clamped period"; pq.push_back(2); pq.push_back(2);
    drain(50);

    // R5 R7: pairs, divide 2, period 20, dead 3
    setup(1, 1, 20, 8, 15, 0, 2, 1);
    step(100);
    push_w(0, "R5 pair0 high side", 13, 2);
    push_w(1, "R5 pair0 low side", 21, 2);
    push_w(2, "R5 pair1 high side", 27, 2);
    push_w(3, "R5 pair1 low side", 7, 2);
    ptag = "R5 pair period"; pq.push_back(40); pq.push_back(40);
    gtag = "R7 dead gap"; gq.push_back(3); gq.push_back(3);
    drain(400);

    // R8: dead 5 suppresses 5-clock runs
    setup(1, 0, 20, 5, 15, 0, 4, 1);
    step(60);
    push_w(1, "R8 pair0 low side", 10, 2);
    push_w(2, "R8 pair1 high side", 10, 2);
    drain(200);
    high_count(80, hc);
    check("R8 pair0 high side suppressed", hc[0], 0);
    check("R8 pair1 low side suppressed", hc[3], 0);

    // R10: interrupt decimation
    setup(0, 0, 5, 2, 0, 0, 0, 3);
    step(40);
    itag = "R10 irq every 3 periods"; iq.push_back(15); iq.push_back(15);
    drain(200);
    setup(0, 0, 5, 2, 0, 0, 0, 0);
    step(20);
    itag = "R10 irq count 0"; iq.push_back(5); iq.push_back(5);
    drain(100);
    setup(0, 0, 5, 2, 0, 0, 0, 1);
    step(20);
    itag = "R10 irq count 1"; iq.push_back(5); iq.push_back(5);
    drain(100);

    // R9: mid-period update applies at the next period
    setup(0, 0, 10, 4, 0, 0, 0, 1);
    step(30);
    pv = out[0];
    forever begin
      step(1);
      if (out[0] && !pv) break;
      pv = out[0];
    end
    @(negedge clk); #1;
    push_w(0, "R9 width after update", 4, 1);
    wq[0].push_back(8);
    ptag = "R9 period after update"; pq.push_back(10); pq.push_back(16);
    period = 16'd16;
    duty = {16'd0, 16'd0, 16'd8};
    drain(200);

    // R1: disable clears outputs
    en = 1'b0;
    step(2);
    check("R1 out after disable", int'(out), 0);
    check("R1 irq after disable", int'(irq), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule